// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block watches a group of up to 32 already-synchronized GPIO pin levels and turns programmable edges into interrupts. Each pin can be armed for rising edges, falling edges, or both. Any armed edge latches that pin's bit in a sticky status word. Software clears a status bit by writing 1 to it.

The 32-bit status word is split into two 16-pin banks. The low half is the even bank and the high half is the odd bank. Each bank drives its own level interrupt line, gated by one bit of a bank-enable register. The eight lowest pins also drive dedicated interrupt lines, which copy their status bits directly.

Software reaches the block through a simple single-cycle register port: a write strobe, a byte address and 32-bit write data, with combinational read data. Edges are seen on pins whatever their direction, so pins driven as outputs can raise interrupts as well.

Top module: `gpio_eirq`

## Requirements
- R1: Rising-edge arming is a per-pin register. Writing 1s at offset 0x14 sets bits and writing 1s at offset 0x18 clears bits. Written 0s change nothing. Both offsets read back the current rising-arm mask.
- R2: Falling-edge arming works the same way, with set at offset 0x1C and clear at offset 0x20. Both offsets read back the falling-arm mask. A pin armed for both polarities latches on either edge.
- R3: A status bit is set at the first clock edge where that pin's level differs from its level at the previous edge, provided the edge's polarity is armed. Edges of an unarmed polarity leave status unchanged. Status reads at offset 0x24.
- R4: Writing at offset 0x24 clears each status bit written as 1. Bits written as 0 are kept.
- R5: When an armed edge and a clear of the same bit happen in the same cycle, the bit stays set.
- R6: `irq_bank[0]` is high while any of status bits 15..0 is set and bank-enable bit 0 is 1. `irq_bank[1]` does the same for bits 31..16 and bank-enable bit 1. The bank-enable register is at offset 0x08, with one bit per bank in bits 1..0.
- R7: `irq_pin[i]` for i = 0..7 equals status bit i, whatever the bank enables hold.
- R8: Synchronous active-low reset clears the arm masks, the status word and the bank enables. Pins that are high when reset is released do not create an edge.
- R9: Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | 32 | Synchronized pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_bank | output | 2 | Bank interrupt lines, even then odd |
| irq_pin | output | 8 | Direct interrupt lines for pins 7..0 |

## Verification
The assertions check on every cycle that a status bit only rises after a matching pin change. They also check that a set bit only falls through a status write that carries no new edge, and that the bank and direct interrupt lines follow status and the bank enables. Reset clearing is checked the same way. The bench's scenarios are the only place that shows polarity selection through the set and clear registers, that written zeros are ignored, and that an edge wins over a clear landing in the same cycle. They also show that a pin high at reset release raises nothing.

// File: rtl/gpio_eirq_pkg.sv
// Shared register offsets of the GPIO edge interrupt aggregator.
package gpio_eirq_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h24;
endpackage

// File: rtl/gpio_eirq_edge.sv
// Edge detector: compares the present pin level with the level held from
// the previous clock and qualifies each change with its polarity arm bit.
// Assumes pin_lvl is already synchronous to clk. The held copy loads the
// live level during reset, so leaving reset never looks like an edge.
module gpio_eirq_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] evt
);
    logic [W-1:0] lvl_q;

    // Hold the previous level; track the pin during reset.
    always_ff @(posedge clk) begin
        lvl_q <= lvl;
    end

    // Qualify each changed pin with the arm bit for its direction.
    always_comb begin
        evt = ((lvl & ~lvl_q) & rise_en) | ((~lvl & lvl_q) & fall_en);
        if (!rst_n) evt = '0;
    end
endmodule

// File: rtl/gpio_eirq_setclr.sv
// Mask register written through separate set and clear strobes: 1s in the
// data set or clear bits, 0s leave them alone. Clear wins if both strobes
// are asserted together (they never are, since offsets differ).
module gpio_eirq_setclr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    // Update the mask from set/clear writes; reset disarms all pins.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (clr_we) mask_q <= mask_q & ~wdata;
        else if (set_we) mask_q <= mask_q | wdata;
    end
endmodule

// File: rtl/gpio_eirq_status.sv
// Sticky event status with write-one-to-clear. A new event is merged after
// the clear, so an event landing with a clear of the same bit survives.
module gpio_eirq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] clr_mask;

    // Only a status write carries a clear mask.
    always_comb clr_mask = clr_we ? wdata : '0;

    // Clear first, then merge fresh events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | evt;
    end
endmodule

// File: rtl/gpio_eirq_banks.sv
// Bank folding: one level interrupt per BANK_W-bit slice of the status
// word, gated by that bank's enable bit. Slice 0 holds the lowest pins.
module gpio_eirq_banks #(
    parameter int W      = 32,
    parameter int BANK_W = 16,
    parameter int NB     = W / BANK_W
) (
    input  logic [W-1:0]  stat,
    input  logic [NB-1:0] bank_en,
    output logic [NB-1:0] irq
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        // OR-reduce one slice and gate with its enable.
        always_comb irq[b] = (|stat[b*BANK_W +: BANK_W]) & bank_en[b];
    end
endmodule

// File: rtl/gpio_eirq.sv
// GPIO edge interrupt aggregator top. Holds the bank-enable register,
// decodes the register port and wires edge detection, status and bank
// folding together. Assumes single-cycle writes and combinational reads.
module gpio_eirq
    import gpio_eirq_pkg::*;
#(
    parameter int PIN_W    = 32,
    parameter int BANK_W   = 16,
    parameter int DIRECT_N = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_lvl,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [PIN_W/BANK_W-1:0] irq_bank,
    output logic [DIRECT_N-1:0] irq_pin
);
    localparam int NB = PIN_W / BANK_W;

    logic [PIN_W-1:0] rise_en, fall_en, evt, stat_q;
    logic [NB-1:0]    bank_en_q;
    logic             we_rs, we_rc, we_fs, we_fc, we_st, we_be;

    // Decode write strobes per offset.
    always_comb begin
        we_rs = reg_wr && (reg_addr == OFS_RISE_SET);
        we_rc = reg_wr && (reg_addr == OFS_RISE_CLR);
        we_fs = reg_wr && (reg_addr == OFS_FALL_SET);
        we_fc = reg_wr && (reg_addr == OFS_FALL_CLR);
        we_st = reg_wr && (reg_addr == OFS_STATUS);
        we_be = reg_wr && (reg_addr == OFS_BANK_EN);
    end

    gpio_eirq_setclr #(.W(PIN_W)) u_rise (
        .clk(clk), .rst_n(rst_n), .set_we(we_rs), .clr_we(we_rc),
        .wdata(reg_wdata[PIN_W-1:0]), .mask_q(rise_en));

    gpio_eirq_setclr #(.W(PIN_W)) u_fall (
        .clk(clk), .rst_n(rst_n), .set_we(we_fs), .clr_we(we_fc),
        .wdata(reg_wdata[PIN_W-1:0]), .mask_q(fall_en));

    gpio_eirq_edge #(.W(PIN_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl),
        .rise_en(rise_en), .fall_en(fall_en), .evt(evt));

    gpio_eirq_status #(.W(PIN_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr_we(we_st),
        .wdata(reg_wdata[PIN_W-1:0]), .stat_q(stat_q));

    gpio_eirq_banks #(.W(PIN_W), .BANK_W(BANK_W), .NB(NB)) u_banks (
        .stat(stat_q), .bank_en(bank_en_q), .irq(irq_bank));

    // Bank-enable register, plain write.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_en_q <= '0;
        else if (we_be) bank_en_q <= reg_wdata[NB-1:0];
    end

    // Direct lines mirror the lowest status bits.
    always_comb irq_pin = stat_q[DIRECT_N-1:0];

    // Read mux; unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_BANK_EN:                 reg_rdata[NB-1:0]    = bank_en_q;
            OFS_RISE_SET, OFS_RISE_CLR:  reg_rdata[PIN_W-1:0] = rise_en;
            OFS_FALL_SET, OFS_FALL_CLR:  reg_rdata[PIN_W-1:0] = fall_en;
            OFS_STATUS:                  reg_rdata[PIN_W-1:0] = stat_q;
            default:                     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_eirq_chk.sv
// Protocol checker for gpio_eirq, bound to every instance. Keeps its own
// two-deep copy of the pin levels to judge which status changes are legal.
module gpio_eirq_chk
    import gpio_eirq_pkg::*;
#(
    parameter int PIN_W = 32,
    parameter int NB    = 2,
    parameter int DN    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PIN_W-1:0]  pin_lvl,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [PIN_W-1:0]  stat,
    input logic [NB-1:0]     ben,
    input logic [NB-1:0]     irq_bank,
    input logic [DN-1:0]     irq_pin
);
    localparam int BW = PIN_W / NB;
    logic [PIN_W-1:0] d1, d2;

    // Two-stage history of pin levels, primed with the live level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1 <= pin_lvl;
            d2 <= pin_lvl;
        end else begin
            d1 <= pin_lvl;
            d2 <= d1;
        end
    end

    AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat)) & ~(d1 ^ d2)) == '0);  // R3

    AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFS_STATUS) |=> (($past(stat) & ~stat) == '0));  // R4

    AST_W1C_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_STATUS)
        |=> ((stat & $past(reg_wdata[PIN_W-1:0]) & ~(d1 ^ d2)) == '0));  // R4

    AST_EVEN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_bank[0] == ((|stat[BW-1:0]) && ben[0]));  // R6

    AST_ODD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_bank[NB-1] == ((|stat[PIN_W-1:PIN_W-BW]) && ben[NB-1]));  // R6

    AST_DIRECT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pin == stat[DN-1:0]);  // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (stat == '0 && ben == '0));  // R8
endmodule

bind gpio_eirq gpio_eirq_chk #(.PIN_W(PIN_W), .NB(PIN_W/BANK_W), .DN(DIRECT_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat(stat_q),
    .ben(bank_en_q), .irq_bank(irq_bank), .irq_pin(irq_pin));

// File: tb/sim_gpio_eirq.sv
module sim_gpio_eirq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_lvl = 32'h8000_0001;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq_bank;
    logic [7:0]  irq_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_eirq u0 (.clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_bank(irq_bank), .irq_pin(irq_pin));

    // Behavioural reference state.
    logic [31:0] m_rise, m_fall, m_stat, m_prev;
    logic [1:0]  m_ben;

    always @(posedge clk) begin
        logic [31:0] ev, clr;
        if (!rst_n) begin
            m_rise = 0; m_fall = 0; m_stat = 0; m_ben = 0; m_prev = pin_lvl;
        end else begin
            ev = 0;
            for (int i = 0; i < 32; i++) begin
                if (pin_lvl[i] && !m_prev[i] && m_rise[i]) ev[i] = 1'b1;
                if (!pin_lvl[i] && m_prev[i] && m_fall[i]) ev[i] = 1'b1;
            end
            clr = (reg_wr && reg_addr == 8'h24) ? reg_wdata : 32'h0;
            m_stat = (m_stat & ~clr) | ev;
            if (reg_wr) begin
                case (reg_addr)
                    8'h14: m_rise = m_rise | reg_wdata;
                    8'h18: m_rise = m_rise & ~reg_wdata;
                    8'h1C: m_fall = m_fall | reg_wdata;
                    8'h20: m_fall = m_fall & ~reg_wdata;
                    8'h08: m_ben  = reg_wdata[1:0];
                    default: ;
                endcase
            end
            m_prev = pin_lvl;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h08: return {30'h0, m_ben};
            8'h14, 8'h18: return m_rise;
            8'h1C, 8'h20: return m_fall;
            8'h24: return m_stat;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq_bank == ((|m_stat[15:0] && m_ben[0]) ? 2'b01 : 2'b00) +
                              ((|m_stat[31:16] && m_ben[1]) ? 2'b10 : 2'b00),
                  "R6 bank lines", {30'h0, irq_bank}, {30'h0, (|m_stat[31:16] && m_ben[1]), (|m_stat[15:0] && m_ben[0])});
            check(irq_pin == m_stat[7:0], "R7 direct lines", {24'h0, irq_pin}, {24'h0, m_stat[7:0]});
            check(reg_rdata == m_read(reg_addr), "R9 read data", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic pins(input logic [31:0] v);
        @(posedge clk); #2;
        pin_lvl = v;
        @(posedge clk); #2;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic irqs(input logic [1:0] eb, input logic [7:0] ep, input string tag);
        @(negedge clk);
        check(irq_bank == eb, tag, {30'h0, irq_bank}, {30'h0, eb});
        check(irq_pin == ep, tag, {24'h0, irq_pin}, {24'h0, ep});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        rd(8'h24, 32'h0, "R8 status after reset, high pins");
        rd(8'h14, 32'h0, "R8 rise arm after reset");
        rd(8'h08, 32'h0, "R8 bank enable after reset");
        // R1 arming through set/clear, zeros ignored
        wr(8'h14, 32'h0001_00FF);
        rd(8'h14, 32'h0001_00FF, "R1 set rise");
        wr(8'h14, 32'h0);
        rd(8'h18, 32'h0001_00FF, "R1 zero write ignored");
        wr(8'h18, 32'h0000_000F);
        rd(8'h14, 32'h0001_00F0, "R1 clear rise");
        // R2 falling arm
        wr(8'h1C, 32'h8000_0010);
        rd(8'h20, 32'h8000_0010, "R2 set fall");
        wr(8'h08, 32'h3);
        rd(8'h08, 32'h3, "R6 bank enable readback");
        // R3 falling edge on pin 31
        pins(32'h0000_0001);
        rd(8'h24, 32'h8000_0000, "R3 fall edge latched");
        irqs(2'b10, 8'h00, "R6 odd bank only");
        // R2 both polarities on pin 4
        pins(32'h0000_0011);
        rd(8'h24, 32'h8000_0010, "R2 rise on dual pin");
        irqs(2'b11, 8'h10, "R7 direct line pin4");
        wr(8'h24, 32'h0000_0010);
        pins(32'h0000_0001);
        rd(8'h24, 32'h8000_0010, "R2 fall on dual pin");
        // R3 disarmed rise on pin 2
        pins(32'h0000_0005);
        rd(8'h24, 32'h8000_0010, "R3 disarmed edge ignored");
        // R4 clears
        wr(8'h24, 32'h0);
        rd(8'h24, 32'h8000_0010, "R4 zero clear ignored");
        wr(8'h24, 32'h8000_0000);
        rd(8'h24, 32'h0000_0010, "R4 w1c");
        irqs(2'b01, 8'h10, "R6 odd bank dropped");
        // R5 edge racing a clear on pin 16
        pins(32'h0001_0005);
        rd(8'h24, 32'h0001_0010, "R3 rise pin16");
        pins(32'h0000_0005);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h0001_0000; pin_lvl = 32'h0001_0005;
        @(posedge clk); #2;
        reg_wr = 1'b0;
        rd(8'h24, 32'h0001_0010, "R5 edge beats clear");
        // R6 / R7 bank gating
        wr(8'h08, 32'h1);
        irqs(2'b01, 8'h10, "R6 odd bank masked");
        wr(8'h24, 32'h10);
        wr(8'h08, 32'h2);
        irqs(2'b10, 8'h00, "R6 odd bank enabled");
        wr(8'h08, 32'h0);
        irqs(2'b00, 8'h00, "R6 all masked");
        wr(8'h08, 32'h1);
        pins(32'h0001_0085);
        irqs(2'b01, 8'h80, "R7 direct line pin7");
        wr(8'h08, 32'h0);
        irqs(2'b00, 8'h80, "R7 direct ignores bank enable");
        // R9 unmapped
        rd(8'h00, 32'h0, "R9 unmapped 0x00");
        rd(8'h30, 32'h0, "R9 unmapped 0x30");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule